// File: doc/BRIEF.md
# Three-Byte Host Write Port with Display Register Bank

The block takes byte writes from a host over an 8-bit parallel bus. A chip-select line qualifies the bus, and a strobe line marks each byte. The block builds each three-byte transfer into an 11-bit address and an 18-bit data word. It then sends that word to one of three places, chosen by address range. The character display memory and the glyph memory each receive a one-cycle write pulse with the address and data. A bank of nine display control registers is held inside the block and presented as a flat parallel output for the rest of the display pipeline.

Three bytes cannot carry 11 address bits and 18 data bits in one transfer. For this reason, data bits 15..8 come from a staging register. The host loads that register with a separate staging transfer, marked by a flag bit in the second byte. An auto-clear input, acting on its falling edge, empties the register bank, the staging register and the byte sequence.

All inputs are sampled on the rising edge of the system clock. A byte is taken when the strobe is seen going from low to high.

Top module: `hwp_host_port`

## Requirements
- R1: After reset, the pulse outputs `disp_we` and `glyph_we` are low and every bit of `ctrl_regs` is zero.
- R2: A byte is taken only on a sampled low-to-high strobe edge while `cs_n` is low. Changes on `din` without such an edge, and strobe edges while `cs_n` is high, have no effect.
- R3: Byte layout. Byte 1 is address[7:0]. Byte 2 holds address[10:8] in bits 2..0, data[17:16] in bits 6..5 and the stage flag in bit 7; bits 4..3 are ignored. Byte 3 is data[7:0]. Data[15:8] is the content of the staging register.
- R4: A transfer whose byte 2 has bit 7 set loads byte 3 into the staging register and produces no write of any kind.
- R5: An address from 0x000 to 0x2A7 raises `disp_we` for exactly one cycle, with `wr_addr` and `wr_data` valid. This happens right after the clock edge that samples the third strobe rise.
- R6: An address from 0x2A8 to 0x2B0 updates control register (address − 0x2A8). That register appears at `ctrl_regs[18*i +: 18]`, and no pulse is raised.
- R7: An address from 0x300 to 0x6EC raises `glyph_we` for exactly one cycle, with `wr_addr` and `wr_data` valid.
- R8: Any other address raises no pulse and leaves every control register unchanged.
- R9: Raising `cs_n` part way through a transfer discards the bytes taken so far. The next byte taken is treated as byte 1.
- R10: A falling edge on `aclr_n` zeroes all control registers and the staging register, and restarts the byte sequence. Holding `aclr_n` low, or raising it again, has no further effect.
- R11: Each completed write transfer produces at most one pulse, on at most one target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Host chip select, active low |
| strb | input | 1 | Host byte strobe; a rising edge takes a byte |
| din | input | 8 | Host byte bus |
| aclr_n | input | 1 | Auto-clear; a falling edge clears the register bank |
| disp_we | output | 1 | One-cycle write pulse to display memory |
| glyph_we | output | 1 | One-cycle write pulse to glyph memory |
| wr_addr | output | 11 | Address of the last memory write |
| wr_data | output | 18 | Data of the last memory write |
| ctrl_regs | output | 162 | Nine 18-bit control registers, register i at bits 18*i+17..18*i |

## Verification
The assertions assume that `strb`, `cs_n` and `aclr_n` are already synchronous to `clk`. They also assume that a strobe stays high, and then low, for at least one full clock period, so that the three edges of one transfer are always separated by whole cycles. The bench drives every input on the falling clock edge and keeps each strobe level for a full period. Under these conditions a write pulse cannot last more than one cycle. The bench sweeps all 2048 addresses, each with a fresh staging value, and checks every pulse and register against a model of the three address ranges.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_DISP  = 2'd1,
    TGT_CREG  = 2'd2,
    TGT_GLYPH = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    SEQ_ADDR_LO = 2'd0,
    SEQ_ADDR_HI = 2'd1,
    SEQ_DATA    = 2'd2
  } seq_e;

  localparam int BYTE_W    = 8;
  localparam int FLAG_BIT  = 7;
  localparam int TOP_LSB   = 5;
  localparam int TOP_W     = 2;
endpackage

// File: rtl/hwp_byte_seq.sv
module hwp_byte_seq
  import hwp_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              strb,
  input  logic [BYTE_W-1:0] din,
  input  logic              aclr_n,
  output logic              word_vld,
  output logic [ADDR_W-1:0] word_addr,
  output logic [DATA_W-1:0] word_data,
  output logic              clear
);
  localparam int HI_AW = ADDR_W - BYTE_W;
  localparam int MID_W = DATA_W - TOP_W - BYTE_W;

  seq_e              idx_q, idx_d;
  logic              strb_q, aclr_q;
  logic [BYTE_W-1:0] lo_q;
  logic [HI_AW-1:0]  hia_q;
  logic [TOP_W-1:0]  top_q;
  logic              flag_q;
  logic [MID_W-1:0]  stage_q, stage_d;
  logic              take, ld_lo, ld_hi, ld_stage;

  assign take  = strb & ~strb_q & ~cs_n;
  assign clear = aclr_q & ~aclr_n;
  assign ld_lo = take & (idx_q == SEQ_ADDR_LO) & ~clear;
  assign ld_hi = take & (idx_q == SEQ_ADDR_HI) & ~clear;
  assign ld_stage = take & (idx_q == SEQ_DATA) & flag_q & ~clear;

  always_comb begin
    idx_d = idx_q;
    if (clear || cs_n) begin
      idx_d = SEQ_ADDR_LO;
    end else if (take) begin
      case (idx_q)
        SEQ_ADDR_LO: idx_d = SEQ_ADDR_HI;
        SEQ_ADDR_HI: idx_d = SEQ_DATA;
        default:     idx_d = SEQ_ADDR_LO;
      endcase
    end
  end

  always_comb begin
    stage_d = stage_q;
    if (clear)         stage_d = '0;
    else if (ld_stage) stage_d = din[MID_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= SEQ_ADDR_LO;
      strb_q  <= 1'b1;
      aclr_q  <= 1'b0;
      stage_q <= '0;
    end else begin
      idx_q   <= idx_d;
      strb_q  <= strb;
      aclr_q  <= aclr_n;
      stage_q <= stage_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hia_q  <= '0;
      top_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ld_lo) lo_q <= din;
      if (ld_hi) begin
        hia_q  <= din[HI_AW-1:0];
        top_q  <= din[TOP_LSB +: TOP_W];
        flag_q <= din[FLAG_BIT];
      end
    end
  end

  assign word_vld  = take & (idx_q == SEQ_DATA) & ~flag_q & ~clear;
  assign word_addr = {hia_q, lo_q};
  assign word_data = {top_q, stage_q, din};

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (idx_q == SEQ_ADDR_LO));
  assert_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !(strb && !strb_q) && !clear) |=> $stable(idx_q));
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (idx_q == SEQ_ADDR_LO && stage_q == '0));
  assert_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && idx_q == SEQ_DATA && flag_q) |-> !word_vld);
endmodule

// File: rtl/hwp_addr_decode.sv
module hwp_addr_decode
  import hwp_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int DISP_HI = 'h2A7,
  parameter int CREG_LO = 'h2A8,
  parameter int NREG    = 9,
  parameter int GLY_LO  = 'h300,
  parameter int GLY_HI  = 'h6EC,
  parameter int IDX_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  reg_idx
);
  localparam logic [ADDR_W-1:0] A_DH = ADDR_W'(DISP_HI);
  localparam logic [ADDR_W-1:0] A_RL = ADDR_W'(CREG_LO);
  localparam logic [ADDR_W-1:0] A_RH = ADDR_W'(CREG_LO + NREG - 1);
  localparam logic [ADDR_W-1:0] A_GL = ADDR_W'(GLY_LO);
  localparam logic [ADDR_W-1:0] A_GH = ADDR_W'(GLY_HI);

  logic [ADDR_W-1:0] offs;
  assign offs    = addr - A_RL;
  assign reg_idx = offs[IDX_W-1:0];

  always_comb begin
    tgt = TGT_NONE;
    if (addr <= A_DH)                    tgt = TGT_DISP;
    else if (addr >= A_RL && addr <= A_RH) tgt = TGT_CREG;
    else if (addr >= A_GL && addr <= A_GH) tgt = TGT_GLYPH;
  end
endmodule

// File: rtl/hwp_ctrl_bank.sv
module hwp_ctrl_bank #(
  parameter int NREG   = 9,
  parameter int DATA_W = 18,
  parameter int IDX_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NREG*DATA_W-1:0] regs
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] q, d;
    logic              en;
    assign en = clr | (we & (idx == IDX_W'(i)));
    assign d  = clr ? '0 : wdata;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end
    assign regs[i*DATA_W +: DATA_W] = q;
  end

  assert_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (regs == '0));
  assert_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !clr) |=> $stable(regs));
endmodule

// File: rtl/hwp_host_port.sv
module hwp_host_port
  import hwp_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 18,
  parameter int NREG    = 9,
  parameter int DISP_HI = 'h2A7,
  parameter int CREG_LO = 'h2A8,
  parameter int GLY_LO  = 'h300,
  parameter int GLY_HI  = 'h6EC
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   strb,
  input  logic [7:0]             din,
  input  logic                   aclr_n,
  output logic                   disp_we,
  output logic                   glyph_we,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [DATA_W-1:0]      wr_data,
  output logic [NREG*DATA_W-1:0] ctrl_regs
);
  localparam int IDX_W = $clog2(NREG);

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic              word_vld, clear;
  logic [ADDR_W-1:0] word_addr;
  logic [DATA_W-1:0] word_data;
  tgt_e              tgt;
  logic [IDX_W-1:0]  reg_idx;
  logic              disp_d, glyph_d, mem_ld, creg_we;

  hwp_byte_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .cs_n(cs_n), .strb(strb), .din(din),
    .aclr_n(aclr_n), .word_vld(word_vld), .word_addr(word_addr),
    .word_data(word_data), .clear(clear));

  hwp_addr_decode #(.ADDR_W(ADDR_W), .DISP_HI(DISP_HI), .CREG_LO(CREG_LO),
    .NREG(NREG), .GLY_LO(GLY_LO), .GLY_HI(GLY_HI), .IDX_W(IDX_W)) u_dec (
    .addr(word_addr), .tgt(tgt), .reg_idx(reg_idx));

  assign disp_d  = word_vld & (tgt == TGT_DISP);
  assign glyph_d = word_vld & (tgt == TGT_GLYPH);
  assign creg_we = word_vld & (tgt == TGT_CREG);
  assign mem_ld  = disp_d | glyph_d;

  hwp_ctrl_bank #(.NREG(NREG), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .clr(clear), .we(creg_we), .idx(reg_idx),
    .wdata(word_data), .regs(ctrl_regs));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      disp_we  <= 1'b0;
      glyph_we <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      disp_we  <= disp_d;
      glyph_we <= glyph_d;
      if (mem_ld) begin
        wr_addr <= word_addr;
        wr_data <= word_data;
      end
    end
  end

  assert_disp_range_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    disp_we |-> (wr_addr <= ADDR_W'(DISP_HI)));
  assert_glyph_range_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    glyph_we |-> (wr_addr >= ADDR_W'(GLY_LO) && wr_addr <= ADDR_W'(GLY_HI)));
  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (disp_we || glyph_we) |=> !(disp_we || glyph_we));
  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({disp_we, glyph_we}));
endmodule

// File: tb/sim_hwp_host_port.sv
module sim_hwp_host_port;
  logic         clk = 1'b0;
  logic         rst_n, cs_n, strb, aclr_n;
  logic [7:0]   din;
  logic         disp_we, glyph_we;
  logic [10:0]  wr_addr;
  logic [17:0]  wr_data;
  logic [161:0] ctrl_regs;

  always #10 clk = ~clk;

  hwp_host_port u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .strb(strb), .din(din),
    .aclr_n(aclr_n), .disp_we(disp_we), .glyph_we(glyph_we),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_regs(ctrl_regs));

  int tests = 0, fails = 0;
  int n_disp = 0, n_glyph = 0;
  logic [17:0] exp_regs [9];
  logic [7:0]  stage_m;

  always @(posedge clk) begin
    if (disp_we)  n_disp++;
    if (glyph_we) n_glyph++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [161:0] model_flat();
    logic [161:0] f;
    for (int i = 0; i < 9; i++) f[i*18 +: 18] = exp_regs[i];
    return f;
  endfunction

  task automatic chk_regs(input string req);
    logic [161:0] m;
    m = model_flat();
    tests++;
    if (ctrl_regs !== m) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, ctrl_regs, m);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); din = b; strb = 1'b1;
    @(negedge clk); strb = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    send_byte(b0); send_byte(b1); send_byte(b2);
    @(negedge clk);
  endtask

  task automatic stage(input logic [7:0] v);
    xfer(8'h00, 8'h80, v);
    stage_m = v;
  endtask

  task automatic write(input logic [10:0] a, input logic [1:0] top, input logic [7:0] lo);
    xfer(a[7:0], {1'b0, top, 2'b00, a[10:8]}, lo);
  endtask

  // Full check of one write against the range model (R5..R8, R11)
  task automatic write_chk(input logic [10:0] a, input logic [1:0] top, input logic [7:0] lo);
    int d0, g0;
    logic [17:0] d;
    d = {top, stage_m, lo};
    d0 = n_disp; g0 = n_glyph;
    write(a, top, lo);
    if (a <= 11'h2A7) begin
      chk(n_disp - d0 == 1 && n_glyph == g0, "R5 disp pulse", n_disp - d0, 1);
      chk(wr_addr == a && wr_data == d, "R5 disp addr/data", {wr_addr, wr_data[17:0]}, {a, d});
    end else if (a <= 11'h2B0) begin
      exp_regs[a - 11'h2A8] = d;
      chk(n_disp == d0 && n_glyph == g0, "R6 no pulse", n_disp + n_glyph, d0 + g0);
      chk_regs("R6 register bank");
    end else if (a >= 11'h300 && a <= 11'h6EC) begin
      chk(n_glyph - g0 == 1 && n_disp == d0, "R7 glyph pulse", n_glyph - g0, 1);
      chk(wr_addr == a && wr_data == d, "R7 glyph addr/data", {wr_addr, wr_data[17:0]}, {a, d});
    end else begin
      chk(n_disp == d0 && n_glyph == g0, "R8 no pulse", n_disp + n_glyph, d0 + g0);
      chk_regs("R8 registers unchanged");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d0, g0;
    rst_n = 1'b0; cs_n = 1'b1; strb = 1'b0; aclr_n = 1'b1; din = 8'h00;
    stage_m = 8'h00;
    for (int i = 0; i < 9; i++) exp_regs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!disp_we && !glyph_we, "R1 pulses low", {disp_we, glyph_we}, 0);
    chk_regs("R1 registers zero");
    cs_n = 1'b0;

    // R3 / R4: staging load gives no pulse, then middle bits appear
    d0 = n_disp; g0 = n_glyph;
    stage(8'hC3);
    chk(n_disp == d0 && n_glyph == g0, "R4 stage no pulse", n_disp + n_glyph, d0 + g0);
    chk_regs("R4 stage leaves registers");
    write_chk(11'h012, 2'b10, 8'h6B);
    chk(wr_data == 18'h2C36B, "R3 layout", wr_data, 18'h2C36B);
    // R3: ignored bits 4..3 of byte 2
    xfer(8'h34, 8'h19, 8'hEE);
    chk(wr_addr == 11'h134 && wr_data == {2'b00, 8'hC3, 8'hEE}, "R3 ignored bits", wr_addr, 11'h134);

    // Sweep every address with a fresh staging value
    for (int a = 0; a < 2048; a++) begin
      stage(8'((a * 37) & 8'hFF));
      write_chk(11'(a), 2'(a), 8'(a) ^ 8'h5A);
    end

    // R2: din changes without a strobe edge are ignored
    stage(8'h11);
    send_byte(8'hA0);
    @(negedge clk); din = 8'hFF;
    @(negedge clk); din = 8'h55;
    send_byte(8'h81 & 8'h07);
    send_byte(8'h3C);
    @(negedge clk);
    chk(wr_addr == 11'h1A0 && wr_data == {2'b00, 8'h11, 8'h3C}, "R2 no strobe", wr_addr, 11'h1A0);
    // R2: strobes with cs_n high are ignored
    d0 = n_disp;
    cs_n = 1'b1;
    xfer(8'h05, 8'h00, 8'h77);
    chk(n_disp == d0, "R2 cs high", n_disp - d0, 0);
    cs_n = 1'b0;
    write_chk(11'h2AA, 2'b01, 8'h42);

    // R9: abort part way through
    send_byte(8'hAB);
    send_byte(8'h02);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    d0 = n_disp;
    write_chk(11'h2AC, 2'b11, 8'h99);
    chk(n_disp == d0, "R9 aborted bytes gave no write", n_disp - d0, 0);

    // R10: auto-clear
    stage(8'h7E);
    send_byte(8'h10);
    @(negedge clk); aclr_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 9; i++) exp_regs[i] = '0;
    stage_m = 8'h00;
    chk_regs("R10 clear on fall");
    write_chk(11'h2B0, 2'b10, 8'h24);
    chk(ctrl_regs[8*18 +: 18] == {2'b10, 8'h00, 8'h24}, "R10 held low no effect",
        ctrl_regs[8*18 +: 18], {2'b10, 8'h00, 8'h24});
    @(negedge clk); aclr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_regs("R10 rise no effect");
    write_chk(11'h021, 2'b01, 8'h0F);
    chk(wr_data == 18'h1000F, "R10 staging cleared", wr_data, 18'h1000F);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule